// File: doc/BRIEF.md
# Split-Lane Dual-Port Synchronous RAM

This block is a two-port synchronous memory of 4096 nine-bit words. Port A and port B can each read or write any word in the same clock cycle. Each word has two lanes: an 8-bit byte lane and a 1-bit side lane. Each lane has its own read/write select and its own output gate. In one cycle a port can therefore write one lane and read the other, move only one lane, or move the whole word.

All address, data and control inputs are registered. A write sampled on one edge is committed to the array on the next edge. Read data appears one edge after its address is sampled. A per-port hold input freezes the input and output registers so that a stalled pipeline keeps its state. A per-port select input deselects the port: nothing is driven and nothing is written.

Turning a lane from read to write needs one dead cycle. If the port stays selected during that turn, the word receives stale data and has to be written again. Tri-state outputs are modelled as per-lane drive flags, and a lane that is not driven reads as zero. Both ports run from one shared clock.

Top module: `split_lane_dpram`

## Requirements
- R1: The array holds 2^12 words of 9 bits, each port addresses it with 12 bits, and both ports may access it in the same cycle; a word written through one port reads back unchanged through the other.
- R2: While a port's hold input is high, its address, data and control registers and its read output keep their values; with hold low they load on the rising clock edge.
- R3: With select low and a lane's read/write input high at edge k, that lane's stored value appears on the port's data output after edge k+1, and its drive flag is 1 if its output-enable input is low.
- R4: Lane 0 is data bits 7:0, controlled by read/write bit 0 and output-enable bit 0; lane 1 is data bit 8, controlled by bit 1 of each; read/write low means write. Any mix of lane read and lane write is allowed in one cycle.
- R5: A port whose select input is high at an edge writes nothing, and after the following edge its drive flags are 0 and its data output is zero.
- R6: A write sampled at edge k (select low, lane read/write low) is stored in the array at edge k+1.
- R7: If a lane's previous captured request on that port was a selected read, the next captured write to that lane stores the data captured with that read instead of the new data. A deselected cycle or a write in between avoids this.
- R8: An output-enable bit that is high forces that lane's drive flag and data bits to zero at once, without a clock edge. Returning it low restores the registered value.
- R9: A read on one port whose output loads on the same edge that commits the other port's write to that address returns the old word. A read loaded on any later edge returns the new word.
- R10: When both ports write the same lane of the same address at the same edge, port A's data is stored. Lanes written by only one port take that port's data.
- R11: After reset, both ports drive no lane, both data outputs are zero, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| holdA | input | 1 | Port A register hold (stall), active high |
| selNA | input | 1 | Port A select, active low |
| wrNA | input | 2 | Port A per-lane read/write, low = write |
| oeNA | input | 2 | Port A per-lane output enable, active low |
| addrA | input | 12 | Port A word address |
| dinA | input | 9 | Port A write data |
| doutA | output | 9 | Port A read data, zero on undriven lanes |
| drvA | output | 2 | Port A per-lane drive flags |
| holdB | input | 1 | Port B register hold (stall), active high |
| selNB | input | 1 | Port B select, active low |
| wrNB | input | 2 | Port B per-lane read/write, low = write |
| oeNB | input | 2 | Port B per-lane output enable, active low |
| addrB | input | 12 | Port B word address |
| dinB | input | 9 | Port B write data |
| doutB | output | 9 | Port B read data, zero on undriven lanes |
| drvB | output | 2 | Port B per-lane drive flags |

## Verification
Most internal faults show up on the other port. A corrupted write enable, a swapped lane mask or a wrong address register leaves a bad word in the array, and the cross-port read sweep sees it two edges after the write is committed. A wrong read-output register or drive flag shows on the issuing port one edge after the address is sampled. Output-gate faults show immediately, with no clock edge. Faults in the turnaround history or the collision priority only show when the matching sequence is replayed, and the stored word is then wrong when it is next read.

// File: rtl/slram_pkg.sv
package slram_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             load;       // registers may load this edge
    logic [LANES-1:0] wrLane;     // lane write commit this edge
    logic [LANES-1:0] staleLane;  // commit uses previous data
    logic [LANES-1:0] rdLane;     // lane read request in flight
  } portStrobe_t;
endpackage

// File: rtl/slram_port_ctrl.sv
module slram_port_ctrl
  import slram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdIn,
  input  logic             selNIn,
  input  logic [LANES-1:0] wrNIn,
  output portStrobe_t      st
);
  logic             reqCe;
  logic [LANES-1:0] reqWrN;
  logic [LANES-1:0] rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCe  <= 1'b0;
      reqWrN <= '1;
      rdPrev <= '0;
    end else if (!holdIn) begin
      rdPrev <= {LANES{reqCe}} & reqWrN;
      reqCe  <= ~selNIn;
      reqWrN <= wrNIn;
    end
  end

  always_comb begin
    st.load      = ~holdIn;
    st.wrLane    = {LANES{reqCe}} & ~reqWrN;
    st.rdLane    = {LANES{reqCe}} & reqWrN;
    st.staleLane = rdPrev & ({LANES{reqCe}} & ~reqWrN);
  end

  // R5: a deselected capture never leads to a write commit
  a_r5_desel_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!holdIn && selNIn) |=> (st.wrLane == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_turn
    // R7: selected read followed by write on the same lane is a stale commit
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rstN)
      (!holdIn && st.rdLane[l] && !selNIn && !wrNIn[l]) |=> st.staleLane[l]);
  end
endmodule

// File: rtl/slram_dpath.sv
module slram_dpath
  import slram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  portStrobe_t [1:0]                  st,
  input  logic [1:0][ADDR_W-1:0]             addrIn,
  input  logic [1:0][BYTE_W:0]               dinIn,
  input  logic [1:0][LANES-1:0]              oeNIn,
  output logic [1:0][BYTE_W:0]               doutOut,
  output logic [1:0][LANES-1:0]              drvOut
);
  localparam int DATA_W = BYTE_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [1:0][ADDR_W-1:0]  addrReg;
  logic [1:0][DATA_W-1:0]  dinReg, dinOld, outReg, wrData;
  logic [1:0][LANES-1:0]   outVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dinReg  <= '0;
      dinOld  <= '0;
      outReg  <= '0;
      outVal  <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (st[p].load) begin
          addrReg[p] <= addrIn[p];
          dinOld[p]  <= dinReg[p];
          dinReg[p]  <= dinIn[p];
          outReg[p]  <= mem[addrReg[p]];
          outVal[p]  <= st[p].rdLane;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      wrData[p][BYTE_W-1:0] = st[p].staleLane[0] ? dinOld[p][BYTE_W-1:0]
                                                 : dinReg[p][BYTE_W-1:0];
      wrData[p][BYTE_W]     = st[p].staleLane[1] ? dinOld[p][BYTE_W]
                                                 : dinReg[p][BYTE_W];
    end
  end

  // port B first, port A last: A wins on a same-lane collision
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      if (st[p].wrLane[0]) mem[addrReg[p]][BYTE_W-1:0] <= wrData[p][BYTE_W-1:0];
      if (st[p].wrLane[1]) mem[addrReg[p]][BYTE_W]     <= wrData[p][BYTE_W];
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      drvOut[p]                 = outVal[p] & ~oeNIn[p];
      doutOut[p][BYTE_W-1:0]    = drvOut[p][0] ? outReg[p][BYTE_W-1:0] : '0;
      doutOut[p][BYTE_W]        = drvOut[p][1] & outReg[p][BYTE_W];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_chk
    // R2: a held port keeps its input and output registers
    a_r2_hold_regs: assert property (@(posedge clk) disable iff (!rstN)
      !st[p].load |=> ($stable(addrReg[p]) && $stable(dinReg[p]) && $stable(outReg[p])));
  end

  // R10: same-address byte-lane collision stores port A data
  a_r10_collision: assert property (@(posedge clk) disable iff (!rstN)
    (st[0].wrLane[0] && st[1].wrLane[0] && addrReg[0] == addrReg[1])
    |=> (mem[$past(addrReg[0])][BYTE_W-1:0] == $past(wrData[0][BYTE_W-1:0])));
endmodule

// File: rtl/split_lane_dpram.sv
module split_lane_dpram
  import slram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdA,
  input  logic              selNA,
  input  logic [1:0]        wrNA,
  input  logic [1:0]        oeNA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [BYTE_W:0]   dinA,
  output logic [BYTE_W:0]   doutA,
  output logic [1:0]        drvA,
  input  logic              holdB,
  input  logic              selNB,
  input  logic [1:0]        wrNB,
  input  logic [1:0]        oeNB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [BYTE_W:0]   dinB,
  output logic [BYTE_W:0]   doutB,
  output logic [1:0]        drvB
);
  logic [1:0]                   holdV, selNV;
  logic [1:0][LANES-1:0]        wrNV, oeNV, drvV;
  logic [1:0][ADDR_W-1:0]       addrV;
  logic [1:0][BYTE_W:0]         dinV, doutV;
  portStrobe_t [1:0]            stV;

  assign holdV = {holdB, holdA};
  assign selNV = {selNB, selNA};
  assign wrNV  = {wrNB, wrNA};
  assign oeNV  = {oeNB, oeNA};
  assign addrV = {addrB, addrA};
  assign dinV  = {dinB, dinA};

  for (genvar p = 0; p < 2; p++) begin : g_port
    slram_port_ctrl u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .holdIn (holdV[p]),
      .selNIn (selNV[p]),
      .wrNIn  (wrNV[p]),
      .st     (stV[p])
    );
  end

  slram_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (stV),
    .addrIn  (addrV),
    .dinIn   (dinV),
    .oeNIn   (oeNV),
    .doutOut (doutV),
    .drvOut  (drvV)
  );

  assign doutA = doutV[0];
  assign doutB = doutV[1];
  assign drvA  = drvV[0];
  assign drvB  = drvV[1];
endmodule

// File: tb/split_lane_dpram_tb.sv
module split_lane_dpram_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdA = 1'b0, selNA = 1'b1, holdB = 1'b0, selNB = 1'b1;
  logic [1:0] wrNA = 2'b11, oeNA = 2'b00, wrNB = 2'b11, oeNB = 2'b00;
  logic [11:0] addrA = '0, addrB = '0;
  logic [8:0] dinA = '0, dinB = '0;
  logic [8:0] doutA, doutB;
  logic [1:0] drvA, drvB;

  int nChk = 0, nBad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  split_lane_dpram u_dut (
    .clk(clk), .rstN(rstN),
    .holdA(holdA), .selNA(selNA), .wrNA(wrNA), .oeNA(oeNA),
    .addrA(addrA), .dinA(dinA), .doutA(doutA), .drvA(drvA),
    .holdB(holdB), .selNB(selNB), .wrNB(wrNB), .oeNB(oeNB),
    .addrB(addrB), .dinB(dinB), .doutB(doutB), .drvB(drvB)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  function automatic logic [8:0] pat(input int a);
    return 9'((a * 37 + (a >> 3) + 11) & 9'h1FF);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setA(input logic s, input logic [1:0] w, input int a, input logic [8:0] d);
    selNA = s; wrNA = w; addrA = 12'(a); dinA = d;
  endtask

  task automatic setB(input logic s, input logic [1:0] w, input int a, input logic [8:0] d);
    selNB = s; wrNB = w; addrB = 12'(a); dinB = d;
  endtask

  // read one word through port B, expect both lanes driven
  task automatic readB(input string req, input int a, input logic [8:0] exp);
    setB(1'b0, 2'b11, a, 9'h0);
    step();
    setB(1'b1, 2'b11, 0, 9'h0);
    step();
    chk(req, {drvB, doutB}, {2'b11, exp});
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    #1;
    // R11: reset state
    chk("R11", {drvA, doutA}, 11'h0);
    chk("R11", {drvB, doutB}, 11'h0);

    // R1 R6: fill every word through port A
    for (int i = 0; i < 4096; i++) begin
      setA(1'b0, 2'b00, i, pat(i));
      step();
    end
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    // R1 R3: pipelined read sweep through port B
    for (int i = 0; i <= 4096; i++) begin
      if (i < 4096) setB(1'b0, 2'b11, i, 9'h0);
      else setB(1'b1, 2'b11, 0, 9'h0);
      step();
      if (i > 0) chk("R1", {drvB, doutB}, {2'b11, pat(i - 1)});
    end

    // R4: write byte lane, read side lane
    setA(1'b0, 2'b10, 5, 9'h055);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R4", {drvA, doutA}, {2'b10, pat(5)[8], 8'h00});
    readB("R4", 5, {pat(5)[8], 8'h55});
    // R4: read byte lane, write side lane
    setA(1'b0, 2'b01, 6, {~pat(6)[8], 8'hEE});
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R4", {drvA, doutA}, {2'b01, 1'b0, pat(6)[7:0]});
    readB("R4", 6, {~pat(6)[8], pat(6)[7:0]});

    // R2: hold freezes registers and output
    setA(1'b0, 2'b11, 7, 9'h0);
    step();
    setA(1'b0, 2'b11, 8, 9'h0);
    step();
    chk("R3", {drvA, doutA}, {2'b11, pat(7)});
    holdA = 1'b1;
    setA(1'b0, 2'b11, 9, 9'h0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2", {drvA, doutA}, {2'b11, pat(7)});
    end
    holdA = 1'b0;
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R2", {drvA, doutA}, {2'b11, pat(8)});
    holdA = 1'b1;
    // R8: output enable is combinational per lane
    oeNA = 2'b01; #1;
    chk("R8", {drvA, doutA}, {2'b10, pat(8)[8], 8'h00});
    oeNA = 2'b11; #1;
    chk("R8", {drvA, doutA}, 11'h0);
    oeNA = 2'b00; #1;
    chk("R8", {drvA, doutA}, {2'b11, pat(8)});
    holdA = 1'b0;
    step();

    // R5: deselected write has no effect, outputs idle
    setA(1'b1, 2'b00, 10, 9'h000);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R5", {drvA, doutA}, 11'h0);
    readB("R5", 10, pat(10));

    // R7: read-to-write without dead cycle stores stale data
    setA(1'b0, 2'b11, 20, 9'h0F0);
    step();
    setA(1'b0, 2'b00, 20, 9'h1C3);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    readB("R7", 20, 9'h0F0);
    setA(1'b0, 2'b00, 20, 9'h1C3);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    readB("R7", 20, 9'h1C3);
    // R7: dead cycle with deselect avoids corruption
    setA(1'b0, 2'b11, 21, 9'h0AA);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    setA(1'b0, 2'b00, 21, 9'h155);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    readB("R7", 21, 9'h155);

    // R9: cross-port visibility around the commit edge
    setA(1'b0, 2'b00, 30, 9'h123);
    setB(1'b0, 2'b11, 30, 9'h0);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R9", {drvB, doutB}, {2'b11, pat(30)});
    setB(1'b1, 2'b11, 0, 9'h0);
    step();
    chk("R9", {drvB, doutB}, {2'b11, 9'h123});

    // R10: full collision, port A wins
    setA(1'b0, 2'b00, 40, 9'h0A5);
    setB(1'b0, 2'b00, 40, 9'h15A);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    setB(1'b1, 2'b11, 0, 9'h0);
    step();
    readB("R10", 40, 9'h0A5);
    step();
    // R10: partial collision, each lane from its writer
    setA(1'b0, 2'b10, 41, 9'h033);
    setB(1'b0, 2'b00, 41, 9'h1CC);
    step();
    setA(1'b1, 2'b11, 0, 9'h0);
    setB(1'b1, 2'b11, 0, 9'h0);
    step();
    readB("R10", 41, 9'h133);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule